// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a single-master I2C controller that a host steers through three small registers. A data register serves both directions. Writing it loads a shift register and clocks the byte out. Reading it returns the byte the shift register already holds and, in the same access, starts a receive that shifts fresh bus bits into that register. A control register holds a 3-bit bit count and an acknowledge-mode enable. Two command bits in the same register request a Start (which also serves as a repeated Start) or a Stop. A status register shows a pending flag and a sticky missing-acknowledge error.

The number of SCL pulses in a transfer is set by the bit count, plus one pulse when acknowledge mode is on. To finish a read, the host turns acknowledge mode off and reads the last byte with eight pulses. It then sets the count to one and reads the data register again. That read hands over the last byte and issues one pulse with SDA released, which the slave takes as a negative acknowledge. The SCL timing comes from a fixed divider of the system clock. Both bus lines are open-drain: an output value of 1 releases the line.

Top module: `i2c_byte_master`

## Requirements
- R1: The status register (address 2) shows pending in bit 0. Pending goes high in the cycle after an accepted command and stays high until that command completes on the bus.
- R2: A write to the data register (address 0) clocks out the top n bits of the byte, MSB first. SDA changes only while SCL is low.
- R3: In a transmit with acknowledge mode on, the bus may be high at the pulse after the data bits. That sets status bit 1. The bit stays clear when the slave pulls SDA low there. A later Start command clears it.
- R4: In a receive with acknowledge mode on, the master holds SDA low throughout the extra pulse that follows the data bits.
- R5: A transfer produces n SCL pulses, plus one when acknowledge mode (control bit 3) is set. The count n is control bits 2:0, where the value 0 means 8.
- R6: A read of the data register returns the byte currently held and starts a receive. When the receive ends, the held byte is the old byte shifted left by n with the n received bits (MSB first) placed in the low end.
- R7: With a count of 1 and acknowledge mode off, a read of the data register produces exactly one pulse with the master releasing SDA.
- R8: Control bit 6 issues a Start, with SDA falling while SCL is high. The Start works from the idle bus and, as a repeated Start, from a bus left with SCL low. Control bit 7 issues a Stop, with SDA rising while SCL is high, and takes precedence over bit 6. No other SDA change happens while SCL is high.
- R9: After a missing acknowledge, a Stop command returns both lines to the released state.
- R10: Writes and data reads that arrive while pending is high are ignored. They leave the control register and the bus activity unchanged.
- R11: After reset both lines are released, pending and the error flag are low, and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (reading data starts a receive) |
| host_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| scl_o | output | 1 | SCL drive, 1 releases the line |
| sda_o | output | 1 | SDA drive, 1 releases the line |
| sda_i | input | 1 | Sensed SDA level on the bus |

## Verification
Transmits are driven with random bytes, counts and acknowledge settings, and the slave randomly acknowledges or refuses. This separates the pulse-count rule from the error flag and shows that partial counts send only the top bits. Receives use random slave bytes and counts, and the held-byte chain is checked from one read to the next. That chain exposes a wrong shift direction or an early hand-over. Directed cases cover the single-pulse negative acknowledge, a refused address followed by Stop and a fresh Start, and commands written while pending. They also cover repeated Starts, which are counted against any stray Stop.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;
  localparam int PUL_W  = 4;
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam int CTL_ACK   = 3;
  localparam int CTL_START = 6;
  localparam int CTL_STOP  = 7;

  typedef enum logic [1:0] {ENG_IDLE, ENG_START, ENG_STOP, ENG_XFER} eng_st_t;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} op_t;

  // data bits moved by one transfer: code 0 stands for a full byte
  function automatic logic [PUL_W-1:0] data_bits(input logic [CNT_W-1:0] c);
    return (c == '0) ? PUL_W'(BYTE_W) : PUL_W'(c);
  endfunction

  function automatic logic [PUL_W-1:0] xfer_pulses(input logic [CNT_W-1:0] c,
                                                   input logic a);
    return data_bits(c) + PUL_W'(a);
  endfunction
endpackage

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt <= '0;
    else if (clr || cnt == CW'(QDIV - 1))       cnt <= '0;
    else                                        cnt <= cnt + 1'b1;
  end

  assign tick = !clr && (cnt == CW'(QDIV - 1));
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  op_t               op,
  input  logic [CNT_W-1:0]  bcnt,
  input  logic              ack_en,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              busy,
  output logic              done_evt,
  output logic              ack_miss,
  output logic              cond_phase,
  output logic              xfer_phase,
  output logic              ack_slot,
  output logic              rx_dir,
  output logic [BYTE_W-1:0] shreg
);
  eng_st_t          st;
  logic [1:0]       q;
  logic [PUL_W-1:0] idx, nb;
  logic             ackm;
  logic             fin_xfer, last_q;

  assign busy       = (st != ENG_IDLE);
  assign cond_phase = (st == ENG_START) || (st == ENG_STOP);
  assign xfer_phase = (st == ENG_XFER);
  assign ack_slot   = xfer_phase && ackm && (idx == nb);
  assign fin_xfer   = (idx + PUL_W'(1)) == (nb + PUL_W'(ackm));
  assign last_q     = tick && (q == 2'd3);
  assign done_evt   = last_q && (cond_phase || (xfer_phase && fin_xfer));
  assign ack_miss   = tick && (q == 2'd2) && ack_slot && !rx_dir && sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; q <= '0; idx <= '0; nb <= '0; ackm <= 1'b0;
      rx_dir <= 1'b0; shreg <= '0; scl_o <= 1'b1; sda_o <= 1'b1;
    end else begin
      if (load_en) shreg <= load_val;
      if (st == ENG_IDLE) begin
        if (go) begin
          q      <= '0;
          idx    <= '0;
          nb     <= data_bits(bcnt);
          ackm   <= ack_en;
          rx_dir <= (op == OP_RX);
          case (op)
            OP_START: st <= ENG_START;
            OP_STOP:  st <= ENG_STOP;
            default:  st <= ENG_XFER;
          endcase
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (st)
          ENG_START: begin
            case (q)
              2'd0: sda_o <= 1'b1;
              2'd1: scl_o <= 1'b1;
              2'd2: sda_o <= 1'b0;
              default: scl_o <= 1'b0;
            endcase
          end
          ENG_STOP: begin
            case (q)
              2'd0: scl_o <= 1'b0;
              2'd1: sda_o <= 1'b0;
              2'd2: scl_o <= 1'b1;
              default: sda_o <= 1'b1;
            endcase
          end
          default: begin
            case (q)
              2'd0: begin
                scl_o <= 1'b0;
                sda_o <= ack_slot ? !rx_dir : (rx_dir | shreg[BYTE_W-1]);
              end
              2'd1: scl_o <= 1'b1;
              2'd2: if (!ack_slot) shreg <= {shreg[BYTE_W-2:0], sda_i};
              default: begin
                scl_o <= 1'b0;
                idx   <= idx + PUL_W'(1);
              end
            endcase
          end
        endcase
        if (done_evt) st <= ENG_IDLE;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [1:0]        host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i
);
  logic [CNT_W-1:0]  ctrl_cnt;
  logic              ctrl_ack;
  logic              bus_err;
  logic              go, pending, tick, load_en;
  op_t               op;
  logic              done_evt, ack_miss, cond_phase, xfer_phase, ack_slot, rx_dir;
  logic [BYTE_W-1:0] shreg;
  logic              wr_ctrl;

  assign wr_ctrl = host_we && (host_addr == REG_CTRL) && !pending;

  always_comb begin
    go = 1'b0;
    op = OP_TX;
    if (!pending) begin
      if (host_we && host_addr == REG_DATA) begin
        go = 1'b1; op = OP_TX;
      end else if (wr_ctrl && (host_wdata[CTL_STOP] || host_wdata[CTL_START])) begin
        go = 1'b1; op = host_wdata[CTL_STOP] ? OP_STOP : OP_START;
      end else if (!host_we && host_re && host_addr == REG_DATA) begin
        go = 1'b1; op = OP_RX;
      end
    end
  end

  assign load_en = go && (op == OP_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_cnt <= '0; ctrl_ack <= 1'b0; bus_err <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_cnt <= host_wdata[CNT_W-1:0];
        ctrl_ack <= host_wdata[CTL_ACK];
      end
      if (ack_miss)                     bus_err <= 1'b1;
      else if (go && op == OP_START)    bus_err <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      REG_DATA: host_rdata = shreg;
      REG_CTRL: host_rdata = BYTE_W'({ctrl_ack, ctrl_cnt});
      REG_STAT: host_rdata = BYTE_W'({bus_err, pending});
      default:  host_rdata = '0;
    endcase
  end

  i2cb_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(go), .tick(tick)
  );

  i2cb_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .op(op),
    .bcnt(ctrl_cnt), .ack_en(ctrl_ack), .load_en(load_en),
    .load_val(host_wdata), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .busy(pending), .done_evt(done_evt), .ack_miss(ack_miss),
    .cond_phase(cond_phase), .xfer_phase(xfer_phase), .ack_slot(ack_slot),
    .rx_dir(rx_dir), .shreg(shreg)
  );
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
  import i2cb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             pending,
  input logic             done_evt,
  input logic             ack_miss,
  input logic             bus_err,
  input logic             cond_phase,
  input logic             xfer_phase,
  input logic             ack_slot,
  input logic             rx_dir,
  input logic             scl_o,
  input logic             sda_o,
  input logic [CNT_W-1:0] bcnt,
  input logic             ack_en
);
  logic             scl_q;
  logic [PUL_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; pcnt <= '0;
    end else begin
      scl_q <= scl_o;
      if (go)                   pcnt <= '0;
      else if (scl_o && !scl_q) pcnt <= pcnt + PUL_W'(1);
    end
  end

  assert_pend_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(go));
  assert_pend_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !pending);
  assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(ack_miss));
  assert_rx_ack_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && ack_slot && rx_dir) |-> !sda_o);
  assert_pulse_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && xfer_phase) |-> (pcnt == xfer_pulses(bcnt, ack_en)));
  assert_sda_high_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> $past(cond_phase));
endmodule

bind i2c_byte_master i2cb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .pending(pending), .done_evt(done_evt),
  .ack_miss(ack_miss), .bus_err(bus_err), .cond_phase(cond_phase),
  .xfer_phase(xfer_phase), .ack_slot(ack_slot), .rx_dir(rx_dir),
  .scl_o(scl_o), .sda_o(sda_o), .bcnt(ctrl_cnt), .ack_en(ctrl_ack)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0, host_re = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       scl_o, sda_o, sda_i;
  logic       slv_sda = 1'b1;

  int checks = 0, errors = 0;
  int pc = 0, starts = 0, stops = 0;
  int cur_nb = 8;
  logic cur_rx = 1'b0, cur_ack = 1'b0, slave_nak = 1'b0;
  logic [7:0] rx_byte = 8'h00, cap = 8'h00, held = 8'h00;
  logic mst_ack = 1'b1, mst_first = 1'b1;

  assign sda_i = sda_o & slv_sda;

  always #4 clk = ~clk;

  i2c_byte_master dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  function automatic logic slave_val(input int i);
    if (cur_rx) return (i < cur_nb) ? rx_byte[7 - i] : 1'b1;
    return (cur_ack && i == cur_nb) ? slave_nak : 1'b1;
  endfunction

  function automatic int nbits(input int c);
    return (c == 0) ? 8 : c;
  endfunction

  function automatic int exp_pulses(input int c, input logic a);
    return nbits(c) + (a ? 1 : 0);
  endfunction

  function automatic logic [7:0] top_bits(input logic [7:0] v, input int n);
    return v >> (8 - n);
  endfunction

  function automatic logic [7:0] shifted(input logic [7:0] old, input logic [7:0] v, input int n);
    logic [15:0] t;
    t = {8'h00, old} << n;
    return t[7:0] | top_bits(v, n);
  endfunction

  function automatic logic [7:0] low_mask(input int n);
    logic [8:0] m;
    m = (9'd1 << n) - 9'd1;
    return m[7:0];
  endfunction

  // bus monitor and slave model
  always @(posedge scl_o) begin
    if (pc < cur_nb) cap = {cap[6:0], sda_i};
    if (pc == cur_nb) mst_ack = sda_o;
    if (pc == 0) mst_first = sda_o;
    pc++;
  end
  always @(negedge scl_o) slv_sda = slave_val(pc);
  always @(negedge sda_i) if (scl_o === 1'b1) starts++;
  always @(posedge sda_i) if (scl_o === 1'b1) stops++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    while (s[0]) host_read(2'd2, s);
  endtask

  task automatic prep(input logic rx, input int c, input logic a);
    cur_rx = rx; cur_nb = nbits(c); cur_ack = a;
    pc = 0; slv_sda = slave_val(0);
  endtask

  task automatic do_cond(input logic stop_cmd);
    int s0, p0;
    logic [7:0] st;
    s0 = starts; p0 = stops;
    prep(1'b0, 0, 1'b0);
    host_write(2'd1, stop_cmd ? 8'h80 : 8'h40);
    host_read(2'd2, st);
    chk(st[0] == 1'b1, "R1 pending after command", st[0], 1);
    wait_idle();
    if (stop_cmd) begin
      chk(stops == p0 + 1 && starts == s0, "R8 stop seen", stops - p0, 1);
      chk(scl_o && sda_o, "R9 lines released after stop", {scl_o, sda_o}, 3);
    end else begin
      chk(starts == s0 + 1 && stops == p0, "R8 start seen", starts - s0, 1);
    end
  endtask

  task automatic do_tx(input logic [7:0] b, input int c, input logic a, input logic nak);
    logic [7:0] st;
    slave_nak = nak;
    prep(1'b0, c, a);
    host_write(2'd1, {4'h0, a, c[2:0]});
    host_write(2'd0, b);
    wait_idle();
    held = shifted(b, b, nbits(c));
    chk(pc == exp_pulses(c, a), "R5 tx pulse count", pc, exp_pulses(c, a));
    chk((cap & low_mask(nbits(c))) == top_bits(b, nbits(c)), "R2 tx bits",
        cap & low_mask(nbits(c)), top_bits(b, nbits(c)));
    host_read(2'd2, st);
    chk(st[1] == (a && nak), "R3 error flag", st[1], a && nak);
  endtask

  task automatic do_rx(input logic [7:0] v, input int c, input logic a);
    logic [7:0] d;
    rx_byte = v;
    host_write(2'd1, {4'h0, a, c[2:0]});
    prep(1'b1, c, a);
    host_read(2'd0, d);
    chk(d == held, "R6 held byte returned", d, held);
    wait_idle();
    held = shifted(held, v, nbits(c));
    chk(pc == exp_pulses(c, a), "R5 rx pulse count", pc, exp_pulses(c, a));
    if (a) chk(mst_ack == 1'b0, "R4 master ack low", mst_ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p0;
    void'($urandom(32'd5179));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    starts = 0; stops = 0;

    // R11 reset state
    chk(scl_o && sda_o, "R11 lines released", {scl_o, sda_o}, 3);
    host_read(2'd2, d); chk(d == 8'h00, "R11 status", d, 0);
    host_read(2'd1, d); chk(d == 8'h00, "R11 control", d, 0);

    // start, address accepted, then refused
    do_cond(1'b0);
    do_tx(8'h41, 0, 1'b1, 1'b0);
    do_tx(8'h9C, 0, 1'b1, 1'b1);
    do_cond(1'b1);                       // R9 stop after error
    host_read(2'd2, d); chk(d[1] == 1'b1, "R3 error sticky over stop", d[1], 1);
    do_cond(1'b0);
    host_read(2'd2, d); chk(d[1] == 1'b0, "R3 start clears error", d[1], 0);

    // R10 commands during pending are dropped
    slave_nak = 1'b0;
    prep(1'b0, 0, 1'b1);
    host_write(2'd1, 8'h08);
    host_write(2'd0, 8'hA5);
    host_write(2'd0, 8'h3C);
    host_write(2'd1, 8'h45);
    host_read(2'd0, d);
    wait_idle();
    held = 8'hA5;
    chk(cap == 8'hA5, "R10 first byte kept", cap, 8'hA5);
    repeat (60) @(negedge clk);
    chk(pc == 9, "R10 no extra transfer", pc, 9);
    host_read(2'd1, d); chk(d == 8'h08, "R10 control unchanged", d, 8'h08);

    // random transmits, each after a repeated start
    for (int i = 0; i < 20; i++) begin
      do_cond(1'b0);
      do_tx(8'($urandom), int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom));
    end

    // random receives
    do_cond(1'b0);
    do_tx(8'hA1, 0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++)
      do_rx(8'($urandom), int'($urandom_range(0, 7)), 1'($urandom));
    do_rx(8'h5A, 0, 1'b1);
    do_rx(8'hC3, 0, 1'b0);

    // R7 one-pulse negative acknowledge
    rx_byte = 8'h80;
    host_write(2'd1, 8'h01);
    prep(1'b1, 1, 1'b0);
    host_read(2'd0, d);
    chk(d == held, "R7 last byte handed over", d, held);
    wait_idle();
    chk(pc == 1, "R7 single pulse", pc, 1);
    chk(mst_first == 1'b1, "R7 sda released", mst_first, 1);
    p0 = stops;
    do_cond(1'b1);
    chk(stops == p0 + 1, "R8 final stop", stops - p0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule